// File: doc/BRIEF.md
# Asynchronous Parallel USB-FIFO Bridge Controller

This controller connects on-chip byte streams to an external USB-to-FIFO bridge device. The bridge has no shared clock. It shows two active-low status levels: "byte waiting for the FPGA" and "room for a byte from the FPGA". It accepts timed, active-low read and write strobes over one 8-bit data bus that both directions share. The controller passes both status levels through a multi-flop synchronizer. One state machine picks a read or a write, times the strobes in clock cycles, and leaves a recovery gap after each strobe before it looks at the flags again.

On the user side, bytes read from the host leave on a valid/ready receive stream, and bytes to send arrive on a valid/ready transmit stream. When the loopback input is high, each byte read from the host goes into an internal holding register and is written back unchanged. The host can then compare what it gets back with what it sent. In loopback both user streams stay quiet. The shared bus is split into an input, an output and an output enable, and a pad-level tri-state buffer outside this block joins them. When the enable is low the bus is released.

States: `ST_IDLE` (decision), `ST_RD_STROBE`, `ST_RD_RECOVER`, `ST_WR_SETUP`, `ST_WR_STROBE`, `ST_WR_HOLD`, `ST_WR_RECOVER`. Transitions:
- `ST_IDLE` → `ST_RD_STROBE` when a read is chosen.
- `ST_IDLE` → `ST_WR_SETUP` when a write is chosen.
- `ST_RD_STROBE` → `ST_RD_RECOVER` when the read timer expires. The byte is captured on this transition.
- `ST_RD_RECOVER` → `ST_IDLE` when the recovery timer expires.
- `ST_WR_SETUP` → `ST_WR_STROBE` always, after one cycle.
- `ST_WR_STROBE` → `ST_WR_HOLD` when the write timer expires.
- `ST_WR_HOLD` → `ST_WR_RECOVER` always, after one cycle.
- `ST_WR_RECOVER` → `ST_IDLE` when the recovery timer expires.

Top module: `fifo_bridge_ctrl`

## Requirements
- R1: During reset and after it, until a transfer starts: both strobes are high, the bus output enable is low, `rx_valid` is low and `tx_ready` is low.
- R2: A read strobe goes low only while the synchronized data-available level is low and no received byte is waiting. It stays low for exactly RD_LOW cycles (default 4). The bus value just before it rises is presented on `rx_data` with `rx_valid` high. That byte is held until `rx_ready` is seen, and no further read starts while it waits.
- R3: A write starts only when a byte is offered (`tx_valid`). `tx_ready` is high in exactly the one cycle in which that byte is taken. The byte is driven with the output enable high for one cycle before the write strobe falls. The strobe stays low for exactly WR_LOW cycles (default 3). Data stays stable while the strobe is low and is still driven in the cycle after it rises.
- R4: The bus output enable is never high while the read strobe is low, and the two strobes are never low together.
- R5: After any strobe rises, both strobes stay high for at least RECOVER+1 cycles (default RECOVER 2) before any strobe falls again. RECOVER must be at least the synchronizer depth.
- R6: When a read and a write are both pending at a decision, the controller takes the direction opposite to the previous transfer. Under continuous demand in both directions, reads and writes alternate.
- R7: With `loopback_en` high, every byte read is written back to the host unchanged and in order. `tx_ready` and `rx_valid` stay low, and offered transmit bytes are left untouched until loopback ends.
- R8: While the synchronized space-available level is high, no write strobe falls and no transmit byte is taken.
- R9: Bytes keep their order in each direction: host-to-user in read order, and user-to-host in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loopback_en | input | 1 | Echo host bytes back to the host; change only while idle |
| host_has_data_n | input | 1 | Asynchronous, low when the bridge holds a byte for the FPGA |
| host_has_space_n | input | 1 | Asynchronous, low when the bridge can take a byte |
| rd_strobe_n | output | 1 | Active-low read strobe to the bridge |
| wr_strobe_n | output | 1 | Active-low write strobe to the bridge |
| bus_in | input | DATA_W | Shared bus value seen at the pad |
| bus_out | output | DATA_W | Byte to drive onto the shared bus |
| bus_oe | output | 1 | High to drive the shared bus, low to release it |
| rx_data | output | DATA_W | Byte read from the host |
| rx_valid | output | 1 | `rx_data` holds an unconsumed byte |
| rx_ready | input | 1 | User accepts `rx_data` |
| tx_data | input | DATA_W | Byte to send to the host |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Offered byte is taken this cycle |

## Verification
The embedded assertions check four things on every cycle: the bus is never driven against a read strobe, both strobes are never low at once, the write data keeps its setup, hold and stability around the write strobe, and an unaccepted received byte stays put with no new read started. Several things need the bench's scenarios to show them, because they depend on traffic over many transfers: the round-robin alternation, back-pressure stalling, flag blocking, loopback echo, the exact strobe widths, the recovery gaps, and end-to-end byte order. The bench models the bridge chip behaviourally with queues.

// File: rtl/fifo_bridge_pkg.sv
package fifo_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STROBE,
        ST_RD_RECOVER,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_HOLD,
        ST_WR_RECOVER
    } bridge_state_e;

endpackage

// File: rtl/fifo_bridge_sync.sv
module fifo_bridge_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // Flags are active-low, so reset to the inactive (high) level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= '1;
        else        pipe[0] <= async_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= '1;
            else        pipe[g] <= pipe[g-1];
        end
    end

    assign sync_o = pipe[STAGES-1];

endmodule

// File: rtl/fifo_bridge_timer.sv
module fifo_bridge_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          expired_o
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (load_i)      cnt <= load_val_i;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired_o = (cnt == '0);

endmodule

// File: rtl/fifo_bridge_ctrl.sv
module fifo_bridge_ctrl
    import fifo_bridge_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int RD_LOW      = 4,
    parameter int WR_LOW      = 3,
    parameter int RECOVER     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loopback_en,
    input  logic              host_has_data_n,
    input  logic              host_has_space_n,
    output logic              rd_strobe_n,
    output logic              wr_strobe_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready
);

    localparam int MAX_A = (RD_LOW > WR_LOW) ? RD_LOW : WR_LOW;
    localparam int MAXC  = (MAX_A > RECOVER) ? MAX_A : RECOVER;
    localparam int CW    = (MAXC < 2) ? 1 : $clog2(MAXC);
    localparam logic [CW-1:0] RD_LOAD  = CW'(RD_LOW - 1);
    localparam logic [CW-1:0] WR_LOAD  = CW'(WR_LOW - 1);
    localparam logic [CW-1:0] REC_LOAD = CW'(RECOVER - 1);

    bridge_state_e state, state_d;

    logic              data_n_s, space_n_s;
    logic              tmr_load, tmr_expired;
    logic [CW-1:0]     tmr_val;
    logic              rd_pend, wr_pend, pick_rd, pick_wr, capture;
    logic              last_rd;
    logic              rx_full, lb_full;
    logic [DATA_W-1:0] rx_byte, lb_byte, wr_byte;
    logic              rd_q, wr_q, oe_q;

    fifo_bridge_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({host_has_data_n, host_has_space_n}),
        .sync_o  ({data_n_s, space_n_s})
    );

    fifo_bridge_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    // Pending requests and round-robin choice
    always_comb begin
        rd_pend = !data_n_s  && (loopback_en ? !lb_full : !rx_full);
        wr_pend = !space_n_s && (loopback_en ? lb_full  : tx_valid);
        pick_rd = rd_pend && (!wr_pend || !last_rd);
        pick_wr = wr_pend && !pick_rd;
    end

    // Next-state logic
    always_comb begin
        state_d  = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (pick_rd) begin
                    state_d  = ST_RD_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = RD_LOAD;
                end else if (pick_wr) begin
                    state_d = ST_WR_SETUP;
                end
            end
            ST_RD_STROBE: begin
                if (tmr_expired) begin
                    state_d  = ST_RD_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = REC_LOAD;
                end
            end
            ST_RD_RECOVER: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            ST_WR_SETUP: begin
                state_d  = ST_WR_STROBE;
                tmr_load = 1'b1;
                tmr_val  = WR_LOAD;
            end
            ST_WR_STROBE: begin
                if (tmr_expired) state_d = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_d  = ST_WR_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = REC_LOAD;
            end
            ST_WR_RECOVER: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign capture  = (state == ST_RD_STROBE) && tmr_expired;
    assign tx_ready = (state == ST_IDLE) && pick_wr && !loopback_en;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Byte holding registers and arbitration memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
            rx_byte <= '0;
            lb_full <= 1'b0;
            lb_byte <= '0;
            wr_byte <= '0;
            last_rd <= 1'b0;
        end else begin
            if (rx_full && rx_ready) rx_full <= 1'b0;
            if (capture) begin
                if (loopback_en) begin
                    lb_full <= 1'b1;
                    lb_byte <= bus_in;
                end else begin
                    rx_full <= 1'b1;
                    rx_byte <= bus_in;
                end
            end
            if (state == ST_IDLE && pick_rd) last_rd <= 1'b1;
            if (state == ST_IDLE && pick_wr) begin
                last_rd <= 1'b0;
                wr_byte <= loopback_en ? lb_byte : tx_data;
                if (loopback_en) lb_full <= 1'b0;
            end
        end
    end

    // Registered pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= 1'b1;
            wr_q <= 1'b1;
            oe_q <= 1'b0;
        end else begin
            rd_q <= (state_d != ST_RD_STROBE);
            wr_q <= (state_d != ST_WR_STROBE);
            oe_q <= (state_d == ST_WR_SETUP) || (state_d == ST_WR_STROBE) ||
                    (state_d == ST_WR_HOLD);
        end
    end

    assign rd_strobe_n = rd_q;
    assign wr_strobe_n = wr_q;
    assign bus_oe      = oe_q;
    assign bus_out     = wr_byte;
    assign rx_data     = rx_byte;
    assign rx_valid    = rx_full;

    // R4: no bus drive while reading
    a_r4_no_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe_n |-> !bus_oe);

    // R4: strobes mutually exclusive
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_strobe_n && !wr_strobe_n));

    // R3: data set up one cycle before the write strobe falls
    a_r3_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_strobe_n) |-> $past(bus_oe));

    // R3: data still driven in the cycle the write strobe rises
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_strobe_n) |-> bus_oe);

    // R3: data stable while the write strobe is low
    a_r3_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_strobe_n && $past(!wr_strobe_n)) |-> $stable(bus_out));

    // R2: unaccepted byte is held
    a_r2_hold_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R2: no new read while a received byte waits
    a_r2_no_read_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_strobe_n) && !loopback_en) |-> !rx_valid);

endmodule

// File: tb/tb_fifo_bridge_ctrl.sv
module tb_fifo_bridge_ctrl;

    localparam int RD_LOW  = 4;
    localparam int WR_LOW  = 3;
    localparam int RECOVER = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loopback_en = 1'b0;
    logic       host_has_data_n = 1'b1;
    logic       host_has_space_n = 1'b0;
    logic       rd_strobe_n, wr_strobe_n, bus_oe;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out, rx_data, tx_data;
    logic       rx_valid, rx_ready, tx_valid, tx_ready;

    always #4 clk = ~clk;

    fifo_bridge_ctrl dut (
        .clk(clk), .rst_n(rst_n), .loopback_en(loopback_en),
        .host_has_data_n(host_has_data_n), .host_has_space_n(host_has_space_n),
        .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    int checks = 0;
    int errors = 0;

    logic [7:0] host_q[$];
    logic [7:0] sink_q[$];
    logic [7:0] exp_sink[$];
    logic [7:0] rx_got[$];
    logic [7:0] exp_rx[$];
    logic [7:0] tx_src[$];
    int         kinds[$];

    bit         rx_ready_en = 1'b1;
    bit         tx_block = 1'b0;
    int         n_reads = 0, n_writes = 0;
    int         cnt_tx_ready = 0, cnt_rx_valid = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Bridge-chip model and per-clock protocol checks
    logic       prev_rd = 1'b1, prev_wr = 1'b1, prev_oe = 1'b0;
    int         rd_run = 0, wr_run = 0, idle_run = 100;
    logic [7:0] wr_at_fall = 8'h00;
    bit         rx_take = 1'b0, tx_take = 1'b0;
    logic [7:0] rx_sample = 8'h00;

    always @(negedge clk) begin
        rx_take = 1'b0;
        tx_take = 1'b0;
        if (rst_n) begin
            if (!rd_strobe_n && !wr_strobe_n) chk(1'b0, "R4 both strobes low", 1, 0);
            if (!rd_strobe_n && bus_oe)       chk(1'b0, "R4 drive during read", 1, 0);
            // read strobe
            if (prev_rd && !rd_strobe_n) begin
                chk(idle_run >= RECOVER + 1, "R5 gap before read", idle_run, RECOVER + 1);
                chk(host_q.size() > 0, "R2 read with no data", host_q.size(), 1);
                if (host_q.size() > 0) bus_in = host_q[0];
                kinds.push_back(0);
            end
            if (!rd_strobe_n) rd_run++;
            if (!prev_rd && rd_strobe_n) begin
                chk(rd_run == RD_LOW, "R2 read strobe width", rd_run, RD_LOW);
                rd_run = 0;
                n_reads++;
                if (host_q.size() > 0) begin
                    if (loopback_en) exp_sink.push_back(host_q[0]);
                    else             exp_rx.push_back(host_q[0]);
                    void'(host_q.pop_front());
                end
            end
            // write strobe
            if (prev_wr && !wr_strobe_n) begin
                chk(prev_oe == 1'b1, "R3 setup drive", prev_oe, 1);
                chk(idle_run >= RECOVER + 1, "R5 gap before write", idle_run, RECOVER + 1);
                wr_at_fall = bus_out;
                kinds.push_back(1);
            end
            if (!wr_strobe_n) begin
                wr_run++;
                if (bus_out != wr_at_fall) chk(1'b0, "R3 data stable", bus_out, wr_at_fall);
            end
            if (!prev_wr && wr_strobe_n) begin
                chk(bus_oe == 1'b1, "R3 hold drive", bus_oe, 1);
                chk(wr_run == WR_LOW, "R3 write strobe width", wr_run, WR_LOW);
                wr_run = 0;
                n_writes++;
                sink_q.push_back(bus_out);
            end
            if (rd_strobe_n && wr_strobe_n) idle_run++;
            else                            idle_run = 0;
            if (tx_ready) cnt_tx_ready++;
            if (rx_valid) cnt_rx_valid++;
            if (rx_valid && rx_ready) begin
                rx_take = 1'b1;
                rx_sample = rx_data;
            end
            if (tx_valid && tx_ready) tx_take = 1'b1;
            prev_rd = rd_strobe_n;
            prev_wr = wr_strobe_n;
            prev_oe = bus_oe;
        end
        host_has_data_n = (host_q.size() == 0);
    end

    // User stream driver, just after each rising edge
    always @(posedge clk) begin
        #1;
        if (rx_take) rx_got.push_back(rx_sample);
        if (tx_take && tx_src.size() > 0) begin
            exp_sink.push_back(tx_src[0]);
            void'(tx_src.pop_front());
        end
        rx_take = 1'b0;
        tx_take = 1'b0;
        tx_valid = (tx_src.size() > 0);
        tx_data  = (tx_src.size() > 0) ? tx_src[0] : 8'h00;
        rx_ready = rx_ready_en;
        host_has_space_n = tx_block;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic compare_all(input string req);
        chk(sink_q.size() == exp_sink.size(), {req, " host count"}, sink_q.size(), exp_sink.size());
        for (int i = 0; i < sink_q.size() && i < exp_sink.size(); i++)
            if (sink_q[i] != exp_sink[i]) chk(1'b0, {req, " host byte"}, sink_q[i], exp_sink[i]);
        chk(rx_got.size() == exp_rx.size(), {req, " rx count"}, rx_got.size(), exp_rx.size());
        for (int i = 0; i < rx_got.size() && i < exp_rx.size(); i++)
            if (rx_got[i] != exp_rx[i]) chk(1'b0, {req, " rx byte"}, rx_got[i], exp_rx[i]);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int base, ra, wa, tr0, rv0;
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        rx_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(rd_strobe_n == 1'b1, "R1 rd strobe", rd_strobe_n, 1);
        chk(wr_strobe_n == 1'b1, "R1 wr strobe", wr_strobe_n, 1);
        chk(bus_oe == 1'b0, "R1 bus released", bus_oe, 0);
        chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        chk(tx_ready == 1'b0, "R1 tx_ready", tx_ready, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        step(4);
        @(negedge clk);
        chk(rd_strobe_n && wr_strobe_n && !bus_oe, "R1 idle after reset", bus_oe, 0);
        step(1);

        // R2 R9: plain reads
        foreach (host_q[i]) ;
        host_q.push_back(8'h11); host_q.push_back(8'hA5); host_q.push_back(8'h00);
        host_q.push_back(8'hFF); host_q.push_back(8'h3C);
        step(120);
        compare_all("R2 R9 reads");
        chk(n_reads == 5, "R2 read count", n_reads, 5);

        // R3 R9: plain writes
        tx_src.push_back(8'h5A); tx_src.push_back(8'h01); tx_src.push_back(8'h80);
        tx_src.push_back(8'hC3); tx_src.push_back(8'h7E);
        step(120);
        compare_all("R3 R9 writes");
        chk(n_writes == 5, "R3 write count", n_writes, 5);

        // R6: both directions pending
        base = kinds.size();
        for (int i = 0; i < 4; i++) begin
            host_q.push_back(8'(8'h20 + i));
            tx_src.push_back(8'(8'h40 + i));
        end
        step(200);
        chk(kinds.size() - base == 8, "R6 transfer count", kinds.size() - base, 8);
        for (int i = base + 1; i < kinds.size(); i++)
            chk(kinds[i] != kinds[i-1], "R6 alternation", kinds[i], 1 - kinds[i-1]);
        compare_all("R6 R9 mixed");

        // R2: back-pressure on the receive stream
        rx_ready_en = 1'b0;
        step(2);
        ra = n_reads;
        host_q.push_back(8'h9D); host_q.push_back(8'h42); host_q.push_back(8'hE7);
        step(60);
        @(negedge clk);
        chk(n_reads - ra == 1, "R2 stall single read", n_reads - ra, 1);
        chk(rx_valid == 1'b1, "R2 byte held valid", rx_valid, 1);
        chk(rx_data == 8'h9D, "R2 held byte", rx_data, 8'h9D);
        step(30);
        @(negedge clk);
        chk(n_reads - ra == 1, "R2 still stalled", n_reads - ra, 1);
        chk(rx_data == 8'h9D, "R2 byte stable", rx_data, 8'h9D);
        step(1);
        rx_ready_en = 1'b1;
        step(100);
        compare_all("R2 R9 backpressure");

        // R8: no space at the host side
        tx_block = 1'b1;
        step(6);
        wa = n_writes;
        tr0 = cnt_tx_ready;
        tx_src.push_back(8'hB1); tx_src.push_back(8'h2E); tx_src.push_back(8'h6F);
        step(60);
        chk(n_writes == wa, "R8 no write when full", n_writes - wa, 0);
        chk(cnt_tx_ready == tr0, "R8 no byte taken", cnt_tx_ready - tr0, 0);
        tx_block = 1'b0;
        step(80);
        chk(n_writes - wa == 3, "R8 writes resume", n_writes - wa, 3);
        compare_all("R8 R9 resume");

        // R7: loopback
        loopback_en = 1'b1;
        step(2);
        tr0 = cnt_tx_ready;
        rv0 = cnt_rx_valid;
        wa  = n_writes;
        tx_src.push_back(8'hD0); tx_src.push_back(8'hD1);
        for (int i = 0; i < 6; i++) host_q.push_back(8'(8'h61 + 8'(i * 37)));
        step(200);
        chk(n_writes - wa == 6, "R7 echoed count", n_writes - wa, 6);
        chk(cnt_tx_ready == tr0, "R7 tx stream ignored", cnt_tx_ready - tr0, 0);
        chk(cnt_rx_valid == rv0, "R7 rx stream quiet", cnt_rx_valid - rv0, 0);
        chk(tx_src.size() == 2, "R7 offered bytes untouched", tx_src.size(), 2);
        compare_all("R7 loopback");
        loopback_en = 1'b0;
        step(80);
        chk(tx_src.size() == 0, "R7 bytes sent after loopback", tx_src.size(), 0);
        compare_all("R7 R9 after loopback");

        finish_run();
    end

endmodule